// File: doc/BRIEF.md
# Main Clock Loss and Recovery Monitor

This block watches an external main clock from a free-running internal reference oscillator clock. It reports when the main clock goes quiet and when it comes back. A small control register turns detection on or off. A response-select bit chooses what happens when the clock is lost: either a sticky system reset request, or an interrupt with status bits.

In interrupt mode the block keeps a sticky detect flag and a clock-stopped status bit. When the main clock is lost and it drives the CPU directly, the block also moves the CPU clock select over to the internal oscillator. When the CPU runs from the PLL, the select is left for software to change. Restart detection is armed only after a stop has been recorded.

The main clock is turned into a toggle in its own domain. That toggle is carried into the reference domain through a synchroniser. A stop is declared after STOP_CYCLES reference cycles pass with no synchronised edge. A restart is declared after RESTART_EDGES edges arrive in a row, with each gap shorter than STOP_CYCLES. The clock multiplexer, the PLL and the CPU are outside this block.

Top module: `mclk_watch`

## Requirements
- R1: While the enable bit is 0, a stop or restart of the main clock gives no interrupt, no reset request and no change to any status bit.
- R2: With enable 1 and response-select 0 (reset mode), a stop raises reset_req. reset_req stays 1, whatever the clock does, until rst. No interrupt is given and no status bit changes.
- R3: With enable 1 and response-select 1 (interrupt mode), a stop gives one irq_pulse of exactly one reference cycle and sets det_flag and main_stopped to 1.
- R4: On a stop in interrupt mode with main_direct=1 (main clock is the direct CPU source), cpu_sel_osc becomes 1.
- R5: On a stop in interrupt mode with main_direct=0 (PLL is the CPU source), cpu_sel_osc keeps its value.
- R6: A restart after a recorded stop in interrupt mode gives one irq_pulse, sets det_flag to 1, clears main_stopped to 0 and leaves cpu_sel_osc unchanged.
- R7: A stop is declared only after STOP_CYCLES (default 8) consecutive reference cycles with no synchronised main-clock edge. It is never declared earlier.
- R8: A restart needs RESTART_EDGES (default 4) consecutive edges, each within STOP_CYCLES cycles of the one before. A gap of STOP_CYCLES cycles restarts the count. A running clock gives no restart event until a stop has been recorded.
- R9: det_flag is sticky. A flag write with data 0 clears it. A flag write with data 1 has no effect. An event in the same cycle wins over the clear.
- R10: After rst all outputs are 0 and the control register is 0 (disabled, reset mode). cpu_sel_osc follows a software select write.
- R11: A main clock whose period is shorter than STOP_CYCLES reference cycles, such as 6 cycles, is never reported as stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Always-running internal reference clock |
| rst | input | 1 | Synchronous active-high reset (reference domain) |
| main_clk | input | 1 | External main clock being watched |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_enable | input | 1 | Control write data: detection enable |
| ctl_irq_mode | input | 1 | Control write data: 1 = interrupt response, 0 = reset response |
| flag_wr | input | 1 | Write strobe for the detect flag |
| flag_wdata | input | 1 | Detect flag write data (only 0 acts) |
| sel_wr | input | 1 | Write strobe for the CPU clock select |
| sel_wdata | input | 1 | CPU clock select write data |
| main_direct | input | 1 | 1 when the main clock directly drives the CPU, 0 when the PLL does |
| reset_req | output | 1 | Sticky system reset request |
| irq_pulse | output | 1 | One-cycle interrupt request per stop or restart event |
| det_flag | output | 1 | Sticky detect flag |
| main_stopped | output | 1 | 1 while the main clock is recorded as stopped |
| cpu_sel_osc | output | 1 | CPU clock select, 1 = internal oscillator |

## Verification
The bench stops the main clock right after one of its rising edges. It then checks that main_stopped is still 0 STOP_CYCLES cycles later and 1 some cycles after that. A counter that ignored the synchroniser delay, or was off by one, would report too early. It sends bursts of RESTART_EDGES-1 edges separated by long gaps: a design that kept counting across gaps would declare a false restart. A clock period of 6 reference cycles catches a design that reports a slow but valid clock as stopped. Further checks catch a stop that changes the clock select while on the PLL, a detect flag that a write of 1 clears, a reset request that drops when the clock returns, and status that changes while disabled.

// File: rtl/mcw_pkg.sv
package mcw_pkg;

    typedef enum logic {
        MON_PRESENT = 1'b0,
        MON_ABSENT  = 1'b1
    } mon_state_e;

    typedef struct packed {
        logic enable;
        logic irq_mode;
    } mon_ctl_t;

    typedef struct packed {
        logic stop;
        logic restart;
    } mon_evt_t;

    typedef struct packed {
        logic reset_req;
        logic det_flag;
        logic stopped;
        logic cpu_sel;
    } mon_stat_t;

    // Counter width able to hold values 0..n
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/mcw_edge_sync.sv
module mcw_edge_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic main_clk,
    input  logic ref_clk,
    input  logic rst,
    output logic edge_seen
);
    localparam int unsigned CHAIN = SYNC_STAGES + 1;

    // Toggle in the main domain: one level change per rising edge
    logic tgl_q = 1'b0;
    always_ff @(posedge main_clk) begin
        tgl_q <= ~tgl_q;
    end

    logic [CHAIN-1:0] chain_q;

    for (genvar i = 0; i < CHAIN; i++) begin : g_stage
        always_ff @(posedge ref_clk) begin
            if (rst) begin
                chain_q[i] <= 1'b0;
            end else if (i == 0) begin
                chain_q[i] <= tgl_q;
            end else begin
                chain_q[i] <= chain_q[(i == 0) ? 0 : i - 1];
            end
        end
    end

    assign edge_seen = chain_q[CHAIN-1] ^ chain_q[CHAIN-2];

endmodule

// File: rtl/mcw_activity.sv
module mcw_activity
    import mcw_pkg::*;
#(
    parameter int unsigned STOP_CYCLES   = 8,
    parameter int unsigned RESTART_EDGES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       edge_seen,
    output mon_evt_t   evt,
    output mon_state_e state
);
    localparam int unsigned GW = cnt_bits(STOP_CYCLES);
    localparam int unsigned RW = cnt_bits(RESTART_EDGES);
    localparam logic [GW-1:0] GAP_LAST = GW'(STOP_CYCLES - 1);
    localparam logic [RW-1:0] RUN_LAST = RW'(RESTART_EDGES - 1);

    mon_state_e    state_q;
    logic [GW-1:0] gap_q;
    logic [RW-1:0] run_q;
    logic          gap_hit;
    logic          run_hit;

    assign gap_hit = !edge_seen && (gap_q == GAP_LAST);
    assign run_hit = edge_seen && (run_q == RUN_LAST);

    always_comb begin
        evt.stop    = enable && (state_q == MON_PRESENT) && gap_hit;
        evt.restart = enable && (state_q == MON_ABSENT) && run_hit;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state_q <= MON_PRESENT;
            gap_q   <= '0;
            run_q   <= '0;
        end else begin
            // cycles since the last synchronised edge, saturating
            if (edge_seen) begin
                gap_q <= '0;
            end else if (!gap_hit) begin
                gap_q <= gap_q + 1'b1;
            end

            // consecutive-edge run, only while absent
            if (state_q == MON_ABSENT && !evt.restart) begin
                if (edge_seen) begin
                    run_q <= run_q + 1'b1;
                end else if (gap_hit) begin
                    run_q <= '0;
                end
            end else begin
                run_q <= '0;
            end

            if (evt.stop) begin
                state_q <= MON_ABSENT;
            end else if (evt.restart) begin
                state_q <= MON_PRESENT;
            end
        end
    end

    assign state = state_q;

endmodule

// File: rtl/mcw_respond.sv
module mcw_respond
    import mcw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ctl_wr,
    input  mon_ctl_t  ctl_wdata,
    input  logic      flag_wr,
    input  logic      flag_wdata,
    input  logic      sel_wr,
    input  logic      sel_wdata,
    input  logic      main_direct,
    input  mon_evt_t  evt,
    output mon_ctl_t  ctl,
    output mon_stat_t stat,
    output logic      irq
);
    mon_ctl_t  ctl_q;
    mon_stat_t stat_q;
    logic      irq_q;
    logic      int_stop;
    logic      int_restart;
    logic      rst_stop;

    assign int_stop    = ctl_q.irq_mode && evt.stop;
    assign int_restart = ctl_q.irq_mode && evt.restart;
    assign rst_stop    = !ctl_q.irq_mode && evt.stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (ctl_wr) begin
                ctl_q <= ctl_wdata;
            end

            irq_q <= int_stop || int_restart;

            if (rst_stop) begin
                stat_q.reset_req <= 1'b1;
            end

            if (int_stop || int_restart) begin
                stat_q.det_flag <= 1'b1;
            end else if (flag_wr && !flag_wdata) begin
                stat_q.det_flag <= 1'b0;
            end

            if (int_stop) begin
                stat_q.stopped <= 1'b1;
            end else if (int_restart) begin
                stat_q.stopped <= 1'b0;
            end

            if (int_stop && main_direct) begin
                stat_q.cpu_sel <= 1'b1;
            end else if (sel_wr) begin
                stat_q.cpu_sel <= sel_wdata;
            end
        end
    end

    assign ctl  = ctl_q;
    assign stat = stat_q;
    assign irq  = irq_q;

endmodule

// File: rtl/mclk_watch.sv
module mclk_watch
    import mcw_pkg::*;
#(
    parameter int unsigned STOP_CYCLES   = 8,
    parameter int unsigned RESTART_EDGES = 4,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic ref_clk,
    input  logic rst,
    input  logic main_clk,
    input  logic ctl_wr,
    input  logic ctl_enable,
    input  logic ctl_irq_mode,
    input  logic flag_wr,
    input  logic flag_wdata,
    input  logic sel_wr,
    input  logic sel_wdata,
    input  logic main_direct,
    output logic reset_req,
    output logic irq_pulse,
    output logic det_flag,
    output logic main_stopped,
    output logic cpu_sel_osc
);
    mon_ctl_t   ctl_wdata;
    mon_ctl_t   ctl_q;
    mon_stat_t  stat;
    mon_evt_t   evt;
    mon_state_e mon_state;
    logic       edge_seen;
    logic       ctl_en;
    logic       ctl_mode;

    assign ctl_wdata = '{enable: ctl_enable, irq_mode: ctl_irq_mode};
    assign ctl_en    = ctl_q.enable;
    assign ctl_mode  = ctl_q.irq_mode;

    mcw_edge_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .main_clk (main_clk),
        .ref_clk  (ref_clk),
        .rst      (rst),
        .edge_seen(edge_seen)
    );

    mcw_activity #(
        .STOP_CYCLES  (STOP_CYCLES),
        .RESTART_EDGES(RESTART_EDGES)
    ) u_act (
        .clk      (ref_clk),
        .rst      (rst),
        .enable   (ctl_en),
        .edge_seen(edge_seen),
        .evt      (evt),
        .state    (mon_state)
    );

    mcw_respond u_resp (
        .clk        (ref_clk),
        .rst        (rst),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .sel_wr     (sel_wr),
        .sel_wdata  (sel_wdata),
        .main_direct(main_direct),
        .evt        (evt),
        .ctl        (ctl_q),
        .stat       (stat),
        .irq        (irq_pulse)
    );

    assign reset_req    = stat.reset_req;
    assign det_flag     = stat.det_flag;
    assign main_stopped = stat.stopped;
    assign cpu_sel_osc  = stat.cpu_sel;

endmodule

// File: rtl/mcw_checker.sv
module mcw_checker (
    input logic ref_clk,
    input logic rst,
    input logic en_q,
    input logic sel_wr,
    input logic main_direct,
    input logic reset_req,
    input logic irq_pulse,
    input logic det_flag,
    input logic main_stopped,
    input logic cpu_sel_osc
);
    p_quiet_when_off_r1: assert property (@(posedge ref_clk) disable iff (rst)
        !$past(en_q) |-> !irq_pulse);

    p_reset_sticky_r2: assert property (@(posedge ref_clk) disable iff (rst)
        reset_req |=> reset_req);

    p_reset_no_irq_r2: assert property (@(posedge ref_clk) disable iff (rst)
        $rose(reset_req) |-> !irq_pulse);

    p_stop_report_r3: assert property (@(posedge ref_clk) disable iff (rst)
        $rose(main_stopped) |-> (irq_pulse && det_flag));

    p_single_pulse_r3: assert property (@(posedge ref_clk) disable iff (rst)
        $rose(main_stopped) |=> !irq_pulse);

    p_direct_switch_r4: assert property (@(posedge ref_clk) disable iff (rst)
        ($rose(main_stopped) && $past(main_direct)) |-> cpu_sel_osc);

    p_pll_hold_r5: assert property (@(posedge ref_clk) disable iff (rst)
        ($rose(main_stopped) && !$past(main_direct) && !$past(sel_wr))
        |-> $stable(cpu_sel_osc));

    p_restart_report_r6: assert property (@(posedge ref_clk) disable iff (rst)
        $fell(main_stopped) |-> (irq_pulse && det_flag));

    p_restart_sel_r6: assert property (@(posedge ref_clk) disable iff (rst)
        ($fell(main_stopped) && !$past(sel_wr)) |-> $stable(cpu_sel_osc));

endmodule

bind mclk_watch mcw_checker u_chk (
    .ref_clk     (ref_clk),
    .rst         (rst),
    .en_q        (ctl_en),
    .sel_wr      (sel_wr),
    .main_direct (main_direct),
    .reset_req   (reset_req),
    .irq_pulse   (irq_pulse),
    .det_flag    (det_flag),
    .main_stopped(main_stopped),
    .cpu_sel_osc (cpu_sel_osc)
);

// File: tb/mclk_watch_test.sv
`timescale 1ns/1ps
module mclk_watch_test;
    localparam int STOP_N  = 8;
    localparam int RUN_M   = 4;
    localparam int STEP_CY = 60;

    typedef struct packed {
        logic       en;
        logic       mode;
        logic       direct;
        logic       clk_on;
        logic       wsel0;
        logic       clr;
        logic       e_stop;
        logic       e_det;
        logic       e_sel;
        logic       e_rst;
        logic [1:0] e_irq;
    } vec_t;

    // en mode direct clk_on wsel0 clr | stopped det sel rst irqs
    localparam vec_t VECS [10] = '{
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,2'd0}, // R8: running, nothing armed
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b0,2'd1}, // R3 R4: stop, direct
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 1'b0,1'b1,1'b1,1'b0,2'd1}, // R6: restart
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b0,1'b0,2'd1}, // R5: stop on PLL
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1, 1'b0,1'b1,1'b0,1'b0,2'd1}, // R6: restart
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,2'd0}, // R1: disabled stop
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,2'd0}, // R1: disabled restart
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,2'd0}, // R2: reset mode running
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,2'd0}, // R2: reset mode stop
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,2'd0}  // R2: sticky after return
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic main_clk;
    logic gate = 1'b1;
    int   main_half = 10;
    logic ctl_wr = 0, ctl_enable = 0, ctl_irq_mode = 0;
    logic flag_wr = 0, flag_wdata = 0, sel_wr = 0, sel_wdata = 0;
    logic main_direct = 0;
    logic reset_req, irq_pulse, det_flag, main_stopped, cpu_sel_osc;

    int errors = 0;
    int checks = 0;
    int irq_cnt = 0;
    int base;
    bit done = 0;

    always #2.5 clk = ~clk;

    initial begin
        main_clk = 1'b0;
        forever begin
            #(main_half);
            main_clk = gate ? ~main_clk : 1'b0;
        end
    end

    always @(posedge clk) if (!rst && irq_pulse) irq_cnt++;

    mclk_watch #(.STOP_CYCLES(STOP_N), .RESTART_EDGES(RUN_M)) uut (
        .ref_clk(clk), .rst(rst), .main_clk(main_clk),
        .ctl_wr(ctl_wr), .ctl_enable(ctl_enable), .ctl_irq_mode(ctl_irq_mode),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata), .main_direct(main_direct),
        .reset_req(reset_req), .irq_pulse(irq_pulse), .det_flag(det_flag),
        .main_stopped(main_stopped), .cpu_sel_osc(cpu_sel_osc)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic en, input logic mode);
        @(negedge clk);
        ctl_wr = 1; ctl_enable = en; ctl_irq_mode = mode;
        @(negedge clk);
        ctl_wr = 0;
    endtask

    task automatic wr_flag(input logic v);
        @(negedge clk);
        flag_wr = 1; flag_wdata = v;
        @(negedge clk);
        flag_wr = 0;
    endtask

    task automatic wr_sel(input logic v);
        @(negedge clk);
        sel_wr = 1; sel_wdata = v;
        @(negedge clk);
        sel_wr = 0;
    endtask

    task automatic burst(input int n);
        gate = 1'b1;
        repeat (n) @(posedge main_clk);
        gate = 1'b0;
    endtask

    initial begin
        #(150000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cycles(4);
        @(negedge clk) rst = 0;
        cycles(2);
        // R10: reset state
        chk("R10 reset reset_req", reset_req, 0);
        chk("R10 reset irq", irq_pulse, 0);
        chk("R10 reset det_flag", det_flag, 0);
        chk("R10 reset stopped", main_stopped, 0);
        chk("R10 reset sel", cpu_sel_osc, 0);

        foreach (VECS[i]) begin
            base = irq_cnt;
            wr_ctl(VECS[i].en, VECS[i].mode);
            if (VECS[i].wsel0) wr_sel(1'b0);
            main_direct = VECS[i].direct;
            gate = VECS[i].clk_on;
            cycles(STEP_CY);
            chk($sformatf("vec%0d stopped", i), main_stopped, VECS[i].e_stop);
            chk($sformatf("vec%0d det_flag", i), det_flag, VECS[i].e_det);
            chk($sformatf("vec%0d cpu_sel", i), cpu_sel_osc, VECS[i].e_sel);
            chk($sformatf("vec%0d reset_req", i), reset_req, VECS[i].e_rst);
            chk($sformatf("vec%0d irq count", i), irq_cnt - base, int'(VECS[i].e_irq));
            if (VECS[i].clr) wr_flag(1'b0);
        end

        // R10: rst clears the sticky reset request and control
        gate = 1'b1;
        @(negedge clk) rst = 1;
        cycles(2);
        @(negedge clk) rst = 0;
        cycles(1);
        chk("R10 rst clears reset_req", reset_req, 0);
        base = irq_cnt;
        gate = 1'b0;
        cycles(40);
        chk("R10 control disabled after rst", irq_cnt - base + int'(reset_req) + int'(main_stopped), 0);
        gate = 1'b1;

        wr_ctl(1'b1, 1'b1);
        main_direct = 1'b1;
        cycles(40);

        // R11: slow but valid clock, period 6 reference cycles
        base = irq_cnt;
        main_half = 15;
        cycles(300);
        chk("R11 slow clock not stopped", main_stopped, 0);
        chk("R11 slow clock no irq", irq_cnt - base, 0);
        main_half = 10;
        cycles(20);

        // R7: stop timing right after a main rising edge
        @(posedge main_clk);
        gate = 1'b0;
        cycles(STOP_N);
        chk("R7 not stopped early", main_stopped, 0);
        cycles(10);
        chk("R7 stopped after window", main_stopped, 1);

        // R9: write 1 keeps the flag, write 0 clears it
        wr_flag(1'b1);
        chk("R9 write 1 keeps flag", det_flag, 1);
        wr_flag(1'b0);
        chk("R9 write 0 clears flag", det_flag, 0);
        wr_flag(1'b1);
        chk("R9 write 1 does not set flag", det_flag, 0);

        // R8: short bursts split by long gaps do not restart
        base = irq_cnt;
        burst(RUN_M - 1);
        cycles(30);
        burst(RUN_M - 1);
        cycles(30);
        chk("R8 split bursts stay stopped", main_stopped, 1);
        chk("R8 split bursts no irq", irq_cnt - base, 0);
        gate = 1'b1;
        cycles(40);
        chk("R8 full run restarts", main_stopped, 0);
        chk("R8 restart irq", irq_cnt - base, 1);
        chk("R8 restart sets flag", det_flag, 1);

        // R10: software select write
        wr_sel(1'b0);
        chk("R10 sel write 0", cpu_sel_osc, 0);
        wr_sel(1'b1);
        chk("R10 sel write 1", cpu_sel_osc, 1);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule